// File: doc/BRIEF.md
# Write Credit and Persistence Tracker

This block sits on the host side of a channel to a memory module whose media is slow and whose writes land in a buffer on the module. It accepts write, persistent-write and flush requests from the host, forwards each accepted request as a command one cycle later, and decides when a request may go. A write may only go while a credit is held, so the module's buffer never overflows. Credits come back in the metadata of read and status-read responses.

Persistent writes carry a write group ID. Each group has a counter of persistent writes that are still waiting for their explicit completion. A flush targets either one group or all groups. A group is reported persisted once a status response has confirmed its flush and none of its persistent writes is still outstanding. Software polls the `persisted` vector to learn that the point of persistency has been reached. Ordinary writes carry no ID and expect no completion, so they only spend credits.

Top module: `pmw_tracker`

## Requirements
- R1: After reset, `credits` equals CRED_INIT, `cmd_valid` is 0, and `flush_busy` and `persisted` are all zero.
- R2: A write (req_kind 2'b00) or a persistent write (req_kind 2'b01) is accepted only while `credits` is non-zero, and `req_ready` is low for it when `credits` is zero. Each accepted write of either kind removes one credit.
- R3: A response (`rsp_valid`) adds `rsp_credits` to the count. A credit return and a write in the same cycle are netted together, and the count saturates at CRED_MAX.
- R4: A request accepted at a clock edge (`req_valid` and `req_ready` high) appears on `cmd_valid`/`cmd_kind` after that edge. `cmd_group` carries the request group for kinds 2'b01 and 2'b10, and 0 for kinds 2'b00 and 2'b11.
- R5: An accepted persistent write raises its group's pending count and clears that group's `persisted` bit. A `pw_ack_valid` pulse lowers the count of `pw_ack_group`. A persistent write to a group whose count is at its maximum (2^PEND_W-1) is held with `req_ready` low.
- R6: A single-group flush (req_kind 2'b10) sets `flush_busy[req_group]`. A flush of all groups (req_kind 2'b11) sets every `flush_busy` bit. Neither kind needs a credit.
- R7: A single-group flush to a group whose `flush_busy` bit is set is held with `req_ready` low. A flush of all groups is held while any `flush_busy` bit is set.
- R8: A status response (`rsp_valid` with `rsp_is_status`=1) whose `rsp_flush_done` bit g is set clears `flush_busy[g]` and records the flush as confirmed. Done bits for groups that have no flush in progress have no effect.
- R9: `persisted[g]` is 1 exactly when group g's flush is confirmed and its pending count is zero. When pending writes remain at confirmation, the bit rises after the last `pw_ack_valid` for that group.
- R10: The `rsp_flush_done` bits of a read response (`rsp_is_status`=0) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_kind | input | 2 | 00 write, 01 persistent write, 10 flush one group, 11 flush all |
| req_group | input | GW | Write group of the request |
| req_ready | output | 1 | Request can be accepted this cycle |
| cmd_valid | output | 1 | Command issued toward the module |
| cmd_kind | output | 2 | Kind of the issued command |
| cmd_group | output | GW | Group of the issued command |
| rsp_valid | input | 1 | Read or status response metadata present |
| rsp_is_status | input | 1 | Response is a status read |
| rsp_credits | input | RET_W | Credits returned in the response |
| rsp_flush_done | input | NGROUPS | Per-group flush-complete flags (status only) |
| pw_ack_valid | input | 1 | Persistent-write completion present |
| pw_ack_group | input | GW | Group of the completed persistent write |
| credits | output | CW | Credits currently held |
| flush_busy | output | NGROUPS | Flush in progress per group |
| persisted | output | NGROUPS | Point of persistency reached per group |

## Verification
The bench builds the block with CRED_INIT=4, CRED_MAX=6 and PEND_W=2. With so few credits, the buffer runs dry after four writes. A return of seven credits then shows the saturation at six. With the two-bit pending counter, a group fills after three persistent writes, so the stall on a full group is within reach. Eight groups are kept, so a done flag for a group that has no flush in progress and a flush of all groups can both be exercised.

// File: rtl/pmw_pkg.sv
// Shared types of the write credit and persistence tracker.
package pmw_pkg;
    typedef enum logic [1:0] {
        K_WRITE     = 2'b00,
        K_PWRITE    = 2'b01,
        K_FLUSH_ONE = 2'b10,
        K_FLUSH_ALL = 2'b11
    } req_kind_e;
endpackage

// File: rtl/pmw_credit.sv
// Write credit counter.
// Holds the number of free write-buffer slots on the module. One credit is
// taken per issued write, and returned credits are added in the same cycle.
// The count saturates at CRED_MAX.
// Assumes: take is asserted only while credits is non-zero.
module pmw_credit #(
    parameter int CRED_INIT = 32,
    parameter int CRED_MAX  = 32,
    parameter int CW        = 6,
    parameter int RET_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic             ret_valid,
    input  logic [RET_W-1:0] ret_count,
    output logic [CW-1:0]    credits
);
    localparam int SW = (CW > RET_W ? CW : RET_W) + 2;

    logic [SW-1:0] sum;

    // Net the returned credits against the taken credit.
    always_comb begin
        sum = SW'(credits) - SW'(take);
        if (ret_valid) sum = sum + SW'(ret_count);
    end

    // Register the count, clipped at the maximum.
    always_ff @(posedge clk) begin
        if (!rst_n)                  credits <= CW'(CRED_INIT);
        else if (sum > SW'(CRED_MAX)) credits <= CW'(CRED_MAX);
        else                          credits <= CW'(sum);
    end

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        credits <= CW'(CRED_MAX));
    p_take_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        take && !ret_valid |=> credits == $past(credits) - 1'b1);
    p_no_take_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
        credits == '0 |-> !take);
endmodule

// File: rtl/pmw_group.sv
// State of one write group.
// Counts the group's outstanding persistent writes, tracks whether a flush
// is in progress, and records when that flush has been confirmed by a status
// response. The group is persisted when its flush is confirmed and no
// persistent write is outstanding.
// Assumes: flush_set is asserted only while busy is low, and pw_inc only
// while full is low.
module pmw_group #(
    parameter int PEND_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pw_inc,
    input  logic pw_dec,
    input  logic flush_set,
    input  logic done_in,
    output logic busy,
    output logic full,
    output logic persisted
);
    logic [PEND_W-1:0] pend;
    logic              ack_seen;

    // Count the outstanding persistent writes.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else if (pw_inc && !pw_dec) pend <= pend + 1'b1;
        else if (pw_dec && !pw_inc && pend != '0) pend <= pend - 1'b1;
    end

    // Track the flush in progress.
    always_ff @(posedge clk) begin
        if (!rst_n)         busy <= 1'b0;
        else if (flush_set) busy <= 1'b1;
        else if (done_in)   busy <= 1'b0;
    end

    // Record confirmation. A new write or flush withdraws it.
    always_ff @(posedge clk) begin
        if (!rst_n)                  ack_seen <= 1'b0;
        else if (pw_inc || flush_set) ack_seen <= 1'b0;
        else if (busy && done_in)     ack_seen <= 1'b1;
    end

    // Report the group's status.
    always_comb begin
        full      = (pend == '1);
        persisted = ack_seen && (pend == '0);
    end

    p_flush_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flush_set |=> busy);
    p_done_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy && done_in && !flush_set |=> !busy);
    p_idle_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && done_in && !flush_set && !pw_inc |=> !busy && ack_seen == $past(ack_seen));
    p_pend_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pw_inc && !pw_dec |=> pend == $past(pend) + 1'b1);
    p_persist_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(persisted) |-> $past(busy && done_in) || $past(pw_dec));
endmodule

// File: rtl/pmw_issue.sv
// Request acceptance and command issue.
// Decides whether the request at its input may go, given the credits held
// and the state of every group. It registers the accepted request onto the
// command outputs and fans out the per-group strobes.
// Assumes: req_group is below NGROUPS.
module pmw_issue
    import pmw_pkg::*;
#(
    parameter int NGROUPS = 8,
    parameter int GW      = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [1:0]         req_kind,
    input  logic [GW-1:0]      req_group,
    input  logic               credit_ok,
    input  logic [NGROUPS-1:0] busy,
    input  logic [NGROUPS-1:0] full,
    output logic               req_ready,
    output logic               take,
    output logic [NGROUPS-1:0] pw_inc,
    output logic [NGROUPS-1:0] flush_set,
    output logic               cmd_valid,
    output logic [1:0]         cmd_kind,
    output logic [GW-1:0]      cmd_group
);
    logic accept;

    // Work out whether the current request may go.
    always_comb begin
        case (req_kind_e'(req_kind))
            K_WRITE:     req_ready = credit_ok;
            K_PWRITE:    req_ready = credit_ok && !full[req_group];
            K_FLUSH_ONE: req_ready = !busy[req_group];
            default:     req_ready = (busy == '0);
        endcase
        accept = req_valid && req_ready;
        take   = accept && (req_kind == K_WRITE || req_kind == K_PWRITE);
    end

    // Decode the per-group strobes of an accepted request.
    always_comb begin
        pw_inc    = '0;
        flush_set = '0;
        if (accept) begin
            if (req_kind == K_PWRITE)    pw_inc[req_group]    = 1'b1;
            if (req_kind == K_FLUSH_ONE) flush_set[req_group] = 1'b1;
            if (req_kind == K_FLUSH_ALL) flush_set            = '1;
        end
    end

    // Register the accepted request as the outgoing command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_valid <= 1'b0;
            cmd_kind  <= 2'b00;
            cmd_group <= '0;
        end else begin
            cmd_valid <= accept;
            cmd_kind  <= req_kind;
            if (req_kind == K_PWRITE || req_kind == K_FLUSH_ONE) cmd_group <= req_group;
            else                                                 cmd_group <= '0;
        end
    end

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_kind[1] && !credit_ok |-> !req_ready);
    p_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> cmd_valid && cmd_kind == $past(req_kind));
    p_flush_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_kind == K_FLUSH_ALL && busy != '0 |-> !req_ready);
endmodule

// File: rtl/pmw_tracker.sv
// Write credit and persistence tracker (top).
// Governs host writes to a module with buffered slow-media writes. It holds
// write credits, issues writes, persistent writes and flushes, and reports
// per-group persistency from status responses and persistent-write
// completions.
// Assumes: pw_ack arrives only for groups with outstanding persistent writes.
module pmw_tracker #(
    parameter int  NGROUPS   = 8,
    parameter int  CRED_INIT = 32,
    parameter int  CRED_MAX  = 32,
    parameter int  RET_W     = 4,
    parameter int  PEND_W    = 4,
    localparam int GW        = (NGROUPS > 1) ? $clog2(NGROUPS) : 1,
    localparam int CW        = $clog2(CRED_MAX + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [1:0]         req_kind,
    input  logic [GW-1:0]      req_group,
    output logic               req_ready,
    output logic               cmd_valid,
    output logic [1:0]         cmd_kind,
    output logic [GW-1:0]      cmd_group,
    input  logic               rsp_valid,
    input  logic               rsp_is_status,
    input  logic [RET_W-1:0]   rsp_credits,
    input  logic [NGROUPS-1:0] rsp_flush_done,
    input  logic               pw_ack_valid,
    input  logic [GW-1:0]      pw_ack_group,
    output logic [CW-1:0]      credits,
    output logic [NGROUPS-1:0] flush_busy,
    output logic [NGROUPS-1:0] persisted
);
    logic               take;
    logic [NGROUPS-1:0] pw_inc;
    logic [NGROUPS-1:0] flush_set;
    logic [NGROUPS-1:0] full;

    pmw_credit #(
        .CRED_INIT(CRED_INIT), .CRED_MAX(CRED_MAX), .CW(CW), .RET_W(RET_W)
    ) u_credit (
        .clk(clk), .rst_n(rst_n), .take(take),
        .ret_valid(rsp_valid), .ret_count(rsp_credits), .credits(credits)
    );

    pmw_issue #(.NGROUPS(NGROUPS), .GW(GW)) u_issue (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_kind(req_kind), .req_group(req_group),
        .credit_ok(credits != '0), .busy(flush_busy), .full(full),
        .req_ready(req_ready), .take(take), .pw_inc(pw_inc), .flush_set(flush_set),
        .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_group(cmd_group)
    );

    for (genvar g = 0; g < NGROUPS; g++) begin : g_grp
        pmw_group #(.PEND_W(PEND_W)) u_group (
            .clk(clk), .rst_n(rst_n),
            .pw_inc(pw_inc[g]),
            .pw_dec(pw_ack_valid && (pw_ack_group == GW'(g))),
            .flush_set(flush_set[g]),
            .done_in(rsp_valid && rsp_is_status && rsp_flush_done[g]),
            .busy(flush_busy[g]), .full(full[g]), .persisted(persisted[g])
        );
    end

    p_read_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_is_status && !pw_ack_valid && !req_valid |=> $stable(flush_busy) && $stable(persisted));
endmodule

// File: tb/test_pmw_tracker.sv
// Scoreboard bench: the driver pushes expected commands, and a monitor pops
// and compares them as the design issues them.
module test_pmw_tracker;
    localparam int NG = 8, GW = 3, CI = 4, CM = 6, RW = 3, PW = 2, CW = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, rsp_valid = 1'b0, rsp_is_status = 1'b0, pw_ack_valid = 1'b0;
    logic [1:0] req_kind = 2'b00;
    logic [GW-1:0] req_group = '0, pw_ack_group = '0;
    logic [RW-1:0] rsp_credits = '0;
    logic [NG-1:0] rsp_flush_done = '0;
    logic req_ready, cmd_valid;
    logic [1:0] cmd_kind;
    logic [GW-1:0] cmd_group;
    logic [CW-1:0] credits;
    logic [NG-1:0] flush_busy, persisted;

    int checks = 0, errors = 0, exp_cred = CI;
    logic [4:0] expq[$];

    pmw_tracker #(.NGROUPS(NG), .CRED_INIT(CI), .CRED_MAX(CM), .RET_W(RW), .PEND_W(PW)) i_pmw_tracker (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind), .req_group(req_group),
        .req_ready(req_ready), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_group(cmd_group),
        .rsp_valid(rsp_valid), .rsp_is_status(rsp_is_status), .rsp_credits(rsp_credits),
        .rsp_flush_done(rsp_flush_done), .pw_ack_valid(pw_ack_valid), .pw_ack_group(pw_ack_group),
        .credits(credits), .flush_busy(flush_busy), .persisted(persisted)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor: compare each issued command with the head of the queue (R4).
    always @(negedge clk) begin
        if (rst_n && cmd_valid) begin
            if (expq.size() == 0) chk("R4 unexpected command", 1, 0);
            else chk("R4 command kind/group", int'({cmd_kind, cmd_group}), int'(expq.pop_front()));
        end
    end

    // Driver: present a request that must be accepted, with an optional credit return.
    task automatic issue(input logic [1:0] k, input logic [GW-1:0] g, input int ret);
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_group = g;
        rsp_valid = (ret != 0); rsp_is_status = 1'b0; rsp_credits = RW'(ret);
        #1 chk("R2/R6 request ready", int'(req_ready), 1);
        expq.push_back({k, (k == 2'b01 || k == 2'b10) ? g : 3'd0});
        if (!k[1]) exp_cred = exp_cred - 1;
        exp_cred = exp_cred + ret;
        if (exp_cred > CM) exp_cred = CM;
        @(negedge clk);
        req_valid = 1'b0; rsp_valid = 1'b0; rsp_credits = '0;
        chk("R2/R3 credit count", int'(credits), exp_cred);
    endtask

    // Present a request that must be held, then withdraw it before the edge.
    task automatic blocked(input logic [1:0] k, input logic [GW-1:0] g, input string req);
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_group = g;
        #1 chk(req, int'(req_ready), 0);
        req_valid = 1'b0;
    endtask

    task automatic respond(input logic st, input int ret, input logic [NG-1:0] mask);
        @(negedge clk);
        rsp_valid = 1'b1; rsp_is_status = st; rsp_credits = RW'(ret); rsp_flush_done = mask;
        exp_cred = exp_cred + ret;
        if (exp_cred > CM) exp_cred = CM;
        @(negedge clk);
        rsp_valid = 1'b0; rsp_is_status = 1'b0; rsp_credits = '0; rsp_flush_done = '0;
        chk("R3 credit return", int'(credits), exp_cred);
    endtask

    task automatic pw_ack(input logic [GW-1:0] g);
        @(negedge clk);
        pw_ack_valid = 1'b1; pw_ack_group = g;
        @(negedge clk);
        pw_ack_valid = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        chk("watchdog expired", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset credits", int'(credits), CI);
        chk("R1 reset cmd_valid", int'(cmd_valid), 0);
        chk("R1 reset flush_busy", int'(flush_busy), 0);
        chk("R1 reset persisted", int'(persisted), 0);

        // R2: drain the credits, then writes are held.
        for (int i = 0; i < CI; i++) issue(2'b00, 3'd0, 0);
        blocked(2'b00, 3'd0, "R2 write held at zero credits");
        blocked(2'b01, 3'd4, "R2 persistent write held at zero credits");

        // R3: return, saturate, net.
        respond(1'b0, 2, '0);
        respond(1'b1, 7, '0);
        chk("R3 saturation at max", int'(credits), CM);
        issue(2'b00, 3'd0, 0);
        issue(2'b00, 3'd0, 1);
        chk("R3 netted write and return", int'(credits), 5);

        // R5: fill group 2.
        for (int i = 0; i < 3; i++) issue(2'b01, 3'd2, 0);
        blocked(2'b01, 3'd2, "R5 persistent write held on full group");

        // R6/R7: flush group 2, then repeated flushes stall.
        issue(2'b10, 3'd2, 0);
        chk("R6 flush one sets busy", int'(flush_busy), 8'h04);
        blocked(2'b10, 3'd2, "R7 flush to busy group held");
        blocked(2'b11, 3'd0, "R7 flush all held while busy");

        // R8/R9: confirmation with pending writes, plus a stray done bit.
        respond(1'b1, 0, 8'h24);
        chk("R8 done clears busy", int'(flush_busy), 0);
        chk("R9 not persisted while pending", int'(persisted), 0);
        pw_ack(3'd2);
        pw_ack(3'd2);
        chk("R9 still pending", int'(persisted[2]), 0);
        pw_ack(3'd2);
        chk("R9 persisted after last completion", int'(persisted), 8'h04);

        // R10: read-response done bits ignored.
        issue(2'b10, 3'd3, 0);
        respond(1'b0, 0, 8'h08);
        chk("R10 read done bits ignored busy", int'(flush_busy), 8'h08);
        chk("R10 read done bits ignored persisted", int'(persisted[3]), 0);
        respond(1'b1, 0, 8'h08);
        chk("R9 group 3 persisted", int'(persisted), 8'h0C);

        // R6: flush of all groups.
        issue(2'b11, 3'd5, 0);
        chk("R6 flush all sets every busy", int'(flush_busy), 8'hFF);
        chk("R6 flush withdraws persisted", int'(persisted), 0);
        respond(1'b1, 0, 8'hFF);
        chk("R9 all persisted", int'(persisted), 8'hFF);

        // R5: a new persistent write clears its group's bit.
        issue(2'b01, 3'd1, 0);
        chk("R5 persistent write clears persisted", int'(persisted), 8'hFD);

        repeat (2) @(negedge clk);
        chk("R4 all commands seen", expq.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule